// File: doc/BRIEF.md
# Sample Histogram Accumulator

This block counts how often each sample value occurs over a run of samples. Every incoming sample is used as the address of a bin in an on-chip count memory. The stored count is fetched, one is added to it, and the sum is written back to the same bin. A one-hot controller paces the work in two steps per sample, a fetch step and a store step. It keeps doing this until a run counter reaches its all-ones value, and then it returns to idle.

The whole block is clocked on the falling edge of `clk` and uses a synchronous active-high reset. After reset, an internal sequencer writes zero into every bin. A start request is refused until that clearing has finished. Bins are not cleared again between runs, so successive runs add into the same histogram. While the controller is idle, a host can read any bin through a simple request port. The source of the samples must present each value for two clock cycles, and it may use `src_en` as its advance enable.

Top module: `hist_accum`

## Requirements
- R1: While `rst` is high, at every falling edge `busy`, `acq_done` and `host_valid` go to 0 and `clearing` goes to 1.
- R2: After reset, `clearing` falls at the 2^SAMPLE_W-th falling edge with `rst` low. From then on every bin reads 0.
- R3: A `start` seen while `clearing` is high is ignored, and `busy` stays 0.
- R4: `start` is sampled only at falling edges. A pulse that rises and falls between two falling edges leaves the block idle.
- R5: The falling edge that samples `start` high in idle enters the fetch step. The store step then always follows on the next edge, so `busy` (equal to `src_en`) is 1 for two cycles per sample. The same `sample` value must be held across both steps.
- R6: Each processed sample adds exactly one to its bin. The 16-bit count is stored in two 8-bit lanes, and the carry passes from the low lane into the high lane.
- R7: A run processes exactly 2^(CNT_W-1) samples. On the edge where the block returns to idle, `acq_done` is high for exactly one cycle.
- R8: In idle with clearing finished, a `host_rd` sampled at a falling edge sets `host_valid` to 1 at that edge, with `host_data` equal to the count of bin `host_addr`.
- R9: A `host_rd` sampled during a run or during clearing is ignored, and `host_valid` stays 0.
- R10: A new run adds onto the counts left by earlier runs.
- R11: The run counter is zero whenever the controller is idle, so every run has the same length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a run |
| sample | input | SAMPLE_W | Sample value, used as the bin address |
| host_rd | input | 1 | Host bin read request |
| host_addr | input | SAMPLE_W | Bin to read |
| busy | output | 1 | Controller is in the fetch or store step |
| src_en | output | 1 | Advance enable for the sample source (same as busy) |
| clearing | output | 1 | Bin clearing after reset is in progress |
| acq_done | output | 1 | One-cycle pulse when a run ends |
| host_valid | output | 1 | `host_data` holds the answer to a host read |
| host_data | output | BIN_W | Count of the requested bin |

## Verification
The hardest state to reach is a bin whose count crosses the boundary between the two byte lanes. To get there, the bench repeats the run on a single constant sample value until that bin holds more than 255. It then reads the bin back through the host port.

Refused requests are made on purpose. Start and host reads are issued during clearing, a host read is placed in the middle of a run, and a start pulse that falls before the next falling edge is tried. After each one, the bench checks at the ports that nothing happened. Each run is checked against a per-bin model kept in the bench, and after each run the bench sweeps every bin of the small configuration.

// File: rtl/hist_pkg.sv
package hist_pkg;

  // One flop per controller state; exactly one is set at any time
  typedef struct packed {
    logic idle;
    logic rd;
    logic wr;
  } hist_state_t;

endpackage

// File: rtl/hist_clear.sv
module hist_clear #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  output logic              active,
  output logic [ADDR_W-1:0] addr
);

  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  always_ff @(negedge clk) begin
    if (rst) begin
      active <= 1'b1;
      addr   <= '0;
    end else if (active) begin
      addr <= addr + ADDR_W'(1);
      if (addr == LAST) active <= 1'b0;
    end
  end

  // R2: the sweep visits every address in ascending order
  a_r2_clear_steps: assert property (@(negedge clk) disable iff (rst)
    (active && addr != LAST) |=> (active && addr == $past(addr) + ADDR_W'(1)));

  // R2: the sweep stops once it has written the last address
  a_r2_clear_stops: assert property (@(negedge clk) disable iff (rst)
    (active && addr == LAST) |=> !active);

endmodule

// File: rtl/hist_ctrl.sv
module hist_ctrl
  import hist_pkg::*;
#(
  parameter int CNT_W = 13
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        clr_busy,
  output hist_state_t st,
  output logic        run_en,
  output logic        run_done
);

  logic [CNT_W-1:0] cnt;
  logic             go;
  logic             last;

  assign go     = start & ~clr_busy;
  assign last   = &cnt;
  assign run_en = st.rd | st.wr;

  always_ff @(negedge clk) begin
    if (rst) begin
      st       <= '{idle: 1'b1, rd: 1'b0, wr: 1'b0};
      cnt      <= '0;
      run_done <= 1'b0;
    end else begin
      st.idle  <= (st.wr & last) | (st.idle & ~go);
      st.rd    <= (st.idle & go) | (st.wr & ~last);
      st.wr    <= st.rd;
      cnt      <= run_en ? cnt + CNT_W'(1) : '0;
      run_done <= st.wr & last;
    end
  end

  // R5: the three state flops stay one-hot
  a_r5_onehot: assert property (@(negedge clk) disable iff (rst)
    $onehot({st.idle, st.rd, st.wr}));

  // R5: a fetch step is always followed by a store step
  a_r5_fetch_then_store: assert property (@(negedge clk) disable iff (rst)
    st.rd |=> st.wr);

  // R11: the run counter holds zero while idle
  a_r11_cnt_idle_zero: assert property (@(negedge clk) disable iff (rst)
    st.idle |-> (cnt == '0));

  // R3: no run can begin while clearing is in progress
  a_r3_no_start_clearing: assert property (@(negedge clk) disable iff (rst)
    clr_busy |=> st.idle);

  // R7: the completion pulse lasts a single cycle
  a_r7_done_single: assert property (@(negedge clk) disable iff (rst)
    run_done |=> !run_done);

endmodule

// File: rtl/hist_bin_ram.sv
module hist_bin_ram #(
  parameter int ADDR_W = 12,
  parameter int LANE_W = 8,
  parameter int LANES  = 2
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [ADDR_W-1:0]         waddr,
  input  logic [LANES*LANE_W-1:0]   wdata,
  input  logic                      re,
  input  logic [ADDR_W-1:0]         raddr,
  output logic [LANES*LANE_W-1:0]   rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q;

    always_ff @(negedge clk) begin
      if (we) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
      if (re) q <= mem[raddr];
    end

    assign rdata[g*LANE_W +: LANE_W] = q;
  end

endmodule

// File: rtl/hist_accum.sv
module hist_accum
  import hist_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int CNT_W    = 13,
  parameter int LANE_W   = 8,
  parameter int BIN_W    = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic                host_rd,
  input  logic [SAMPLE_W-1:0] host_addr,
  output logic                busy,
  output logic                src_en,
  output logic                clearing,
  output logic                acq_done,
  output logic                host_valid,
  output logic [BIN_W-1:0]    host_data
);

  localparam int LANES = BIN_W / LANE_W;

  hist_state_t         st;
  logic                run_en;
  logic                clr_active;
  logic [SAMPLE_W-1:0] clr_addr;
  logic                host_ok;
  logic                ram_we;
  logic                ram_re;
  logic [SAMPLE_W-1:0] ram_waddr;
  logic [SAMPLE_W-1:0] ram_raddr;
  logic [BIN_W-1:0]    ram_wdata;
  logic [BIN_W-1:0]    fetched;

  hist_clear #(.ADDR_W(SAMPLE_W)) clr_i (
    .clk    (clk),
    .rst    (rst),
    .active (clr_active),
    .addr   (clr_addr)
  );

  hist_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .clr_busy (clr_active),
    .st       (st),
    .run_en   (run_en),
    .run_done (acq_done)
  );

  // Fetch is issued at the end of the fetch step; the fetched register is
  // the holding value, incremented on its way back into the store step.
  assign host_ok   = host_rd & st.idle & ~clr_active;
  assign ram_re    = st.rd | host_ok;
  assign ram_raddr = st.rd ? sample : host_addr;
  assign ram_we    = clr_active | st.wr;
  assign ram_waddr = clr_active ? clr_addr : sample;
  assign ram_wdata = clr_active ? '0 : fetched + BIN_W'(1);

  hist_bin_ram #(
    .ADDR_W (SAMPLE_W),
    .LANE_W (LANE_W),
    .LANES  (LANES)
  ) ram_i (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .re    (ram_re),
    .raddr (ram_raddr),
    .rdata (fetched)
  );

  always_ff @(negedge clk) begin
    if (rst) host_valid <= 1'b0;
    else     host_valid <= host_ok;
  end

  assign busy      = run_en;
  assign src_en    = run_en;
  assign clearing  = clr_active;
  assign host_data = fetched;

  // R9: an answered host read was issued while idle and not clearing
  a_r9_host_only_idle: assert property (@(negedge clk) disable iff (rst)
    host_valid |-> ($past(st.idle) && !$past(clr_active)));

  // R6: the store step always writes back to a bin, never during clearing
  a_r6_store_not_clearing: assert property (@(negedge clk) disable iff (rst)
    st.wr |-> !clr_active);

  // R5: the sample must be unchanged between fetch and store
  a_r5_sample_held: assert property (@(negedge clk) disable iff (rst)
    st.wr |-> $stable(sample));

endmodule

// File: tb/hist_accum_tb.sv
`timescale 1ns/1ps
module hist_accum_tb_top;

  localparam int SW    = 4;
  localparam int CW    = 4;
  localparam int BW    = 16;
  localparam int NBIN  = 1 << SW;
  localparam int NSAMP = 1 << (CW - 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [SW-1:0] sample = '0;
  logic          host_rd = 1'b0;
  logic [SW-1:0] host_addr = '0;
  logic          busy, src_en, clearing, acq_done, host_valid;
  logic [BW-1:0] host_data;

  int nchk  = 0;
  int nfail = 0;
  int exp_bin [NBIN];

  always #2.5 clk = ~clk;

  hist_accum #(.SAMPLE_W(SW), .CNT_W(CW), .LANE_W(8), .BIN_W(BW)) dut_i (
    .clk, .rst, .start, .sample, .host_rd, .host_addr,
    .busy, .src_en, .clearing, .acq_done, .host_valid, .host_data
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic logic [SW-1:0] pat(input int mode, input int k);
    case (mode)
      0:       return SW'(k);
      1:       return SW'(5);
      2:       return SW'((k * 7 + 3) % NBIN);
      default: return SW'(9);
    endcase
  endfunction

  task automatic host_read(input int a, input string tag);
    @(posedge clk);
    host_rd = 1'b1; host_addr = SW'(a);
    @(posedge clk);
    host_rd = 1'b0;
    chk(host_valid == 1'b1, {tag, " R8 valid"}, int'(host_valid), 1);
    chk(int'(host_data) == exp_bin[a], {tag, " R6 bin count"}, int'(host_data), exp_bin[a]);
  endtask

  task automatic sweep_bins(input string tag);
    for (int a = 0; a < NBIN; a++) host_read(a, tag);
  endtask

  task automatic do_run(input int mode, input bit poke);
    @(posedge clk);
    start = 1'b1; sample = pat(mode, 0);
    for (int k = 0; k < NSAMP; k++) begin
      @(posedge clk);
      start = 1'b0; sample = pat(mode, k);
      chk(busy == 1'b1 && src_en == 1'b1, "R5 busy in fetch step", int'(busy), 1);
      if (poke && k == 1) begin host_rd = 1'b1; host_addr = pat(mode, 0); end
      @(posedge clk);
      chk(busy == 1'b1, "R5 busy in store step", int'(busy), 1);
      if (poke && k == 1) begin
        chk(host_valid == 1'b0, "R9 host read during run", int'(host_valid), 0);
        host_rd = 1'b0;
      end
      exp_bin[pat(mode, k)]++;
    end
    @(posedge clk);
    chk(busy == 1'b0, "R7 R11 idle after 2^(CNT_W-1) samples", int'(busy), 0);
    chk(acq_done == 1'b1, "R7 done pulse", int'(acq_done), 1);
    @(posedge clk);
    chk(acq_done == 1'b0, "R7 done lasts one cycle", int'(acq_done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int n;
    bit quiet;
    for (int a = 0; a < NBIN; a++) exp_bin[a] = 0;
    repeat (3) @(posedge clk);
    chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
    chk(acq_done == 1'b0, "R1 done in reset", int'(acq_done), 0);
    chk(host_valid == 1'b0, "R1 host_valid in reset", int'(host_valid), 0);
    chk(clearing == 1'b1, "R1 clearing in reset", int'(clearing), 1);

    // Release reset and measure the clearing time; poke start and host_rd
    n = clearing ? 1 : 0;
    rst = 1'b0;
    quiet = 1'b1;
    while (clearing && n < 1000) begin
      @(posedge clk);
      if (busy) quiet = 1'b0;
      if (n == 7) chk(host_valid == 1'b0, "R9 host read during clearing", int'(host_valid), 0);
      host_rd = 1'b0;
      start = (n == 3);
      if (n == 6) begin host_rd = 1'b1; host_addr = SW'(2); end
      if (clearing) n++;
    end
    start = 1'b0; host_rd = 1'b0;
    chk(n == NBIN, "R2 clearing length", n, NBIN);
    @(posedge clk);
    chk(quiet && busy == 1'b0, "R3 start ignored while clearing", int'(busy), 0);

    sweep_bins("R2 zero after clear");

    do_run(0, 1'b0);
    sweep_bins("R6 distinct samples");

    do_run(1, 1'b1);
    sweep_bins("R10 accumulate constant run");

    // Short start pulse between falling edges
    @(posedge clk);
    start = 1'b1;
    #1 start = 1'b0;
    quiet = 1'b1;
    repeat (4) begin
      @(posedge clk);
      if (busy) quiet = 1'b0;
    end
    chk(quiet, "R4 narrow start pulse ignored", int'(!quiet), 0);

    do_run(2, 1'b0);
    sweep_bins("R10 scattered samples");

    // Push bin 9 past the low lane to exercise the carry
    repeat (33) do_run(3, 1'b0);
    host_read(9, "R6 lane carry");
    chk(exp_bin[9] > 255, "R6 carry case reached", exp_bin[9], 256);
    sweep_bins("R10 final");

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule